// File: doc/BRIEF.md
# One-Time-Programmable Protection Register with Lock

This block holds eight 16-bit words of one-time-programmable protection data. It is driven by an upstream command decoder, which is not part of this block. The lower four words are fixed factory data, supplied as a parameter, and can only be read. The upper four words belong to the user. The user can program them until a sticky lock is set. Programming can only clear bits: each program request ANDs the written data into the stored word.

The decoder presents one-cycle program, lock and read requests with an address and a data word. The address space is as follows:

- Word i (0 to 7) sits at low-byte address 0x81 + i.
- Address 0x80 carries the lock request.
- A read of address 0x80 returns a status word that reports whether user words can still be changed.

Every address bit above bit 7 must be zero, or the access is invalid. A rejected program request raises a one-cycle error flag. There are two resets:

- A synchronous command reset clears only the read and error outputs.
- An asynchronous power-on reset also clears the lock and returns the user words to all ones.

Top module: `otp_prot_reg`

## Requirements
- R1: After power-on reset, `locked` is 0, `err` is 0, `rvalid` is 0, and every user word reads 0xFFFF.
- R2: A read of low byte 0x81+i (i = 0..3, upper address bits zero) returns bits [16i+15:16i] of the factory parameter. The data appears on `rdata` with `rvalid` high in the cycle after the request.
- R3: A program request to low byte 0x85+j (j = 0..3) while unlocked stores old AND `wdata` into user word j and does not raise `err`. A read of 0x85+j returns user word j.
- R4: A program request to a factory word (0x81..0x84) leaves every word unchanged and raises `err` in the following cycle.
- R5: An address with any bit above bit 7 set, or with a low byte outside 0x80..0x88, is invalid:
  - a program request to it is ignored and raises `err`;
  - a read of it returns 0 with `rvalid` high.
- R6: A lock request with address exactly 0x80 sets `locked` in the following cycle. A lock request at any other address has no effect.
- R7: While locked, a program request to a user word leaves it unchanged and raises `err`.
- R8: A read of 0x80 returns a status word in which bit 1 is 1 when unlocked and 0 when locked, and all other bits are 0.
- R9: A command reset (`rst_n` low at a clock edge) clears `err`, `rvalid` and `rdata`. It leaves the lock and the user words unchanged.
- R10: Only power-on reset clears the lock; it also restores all user words to 0xFFFF.
- R11: `err` is high for exactly one cycle per rejected program request. `rvalid` is high only in the cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_n | input | 1 | Synchronous command reset, active low |
| prog_req | input | 1 | Program request strobe |
| lock_req | input | 1 | Lock request strobe |
| rd_req | input | 1 | Read request strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | DW | Program data |
| rdata | output | DW | Read data |
| rvalid | output | 1 | Read data valid |
| locked | output | 1 | User block is locked |
| err | output | 1 | Rejected program request, one-cycle pulse |

## Verification
The bench sweeps all 256 low-byte addresses for reads. It programs every address from 0x80 to 0x89, so a design with an off-by-one range decode would return factory or user data at the wrong address, or accept a write at 0x80 or 0x89. Repeated programs with overlapping patterns expose a design that overwrites instead of ANDing. Lock requests at 0x81 and at an address with bit 8 set catch a decoder that ignores the upper bits. A command reset issued after locking shows whether the lock wrongly depends on the wrong reset. Status reads before and after the lock catch a design with inverted bit-1 polarity.

// File: rtl/otp_prot_reg.sv
module otp_prot_reg #(
  parameter int ADDR_W = 21,
  parameter int DW = 16,
  parameter logic [4*DW-1:0] FACTORY = 64'h4D2C_0F15_A5A5_1234
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              prog_req,
  input  logic              lock_req,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rvalid,
  output logic              locked,
  output logic              err
);
  logic [3:0][DW-1:0] user_q;
  logic               lock_q;
  logic [7:0]         lo;
  logic               hi_ok, in_rng, is_b, stat_hit, prog_ok;
  logic [2:0]         idx;
  logic [DW-1:0]      rd_word;

  assign lo       = addr[7:0];
  assign hi_ok    = (addr[ADDR_W-1:8] == '0);
  assign in_rng   = hi_ok && (lo >= 8'h81) && (lo <= 8'h88);
  assign idx      = 3'(lo - 8'h81);
  assign is_b     = in_rng && idx[2];
  assign stat_hit = hi_ok && (lo == 8'h80);
  assign prog_ok  = is_b && !lock_q;
  assign locked   = lock_q;

  always_comb begin
    rd_word = '0;
    if (stat_hit)
      rd_word[1] = !lock_q;
    else if (in_rng)
      rd_word = idx[2] ? user_q[idx[1:0]] : FACTORY[idx[1:0]*DW +: DW];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lock_q <= 1'b0;
      user_q <= '1;
    end else begin
      if (lock_req && stat_hit)
        lock_q <= 1'b1;
      if (prog_req && prog_ok)
        user_q[idx[1:0]] <= user_q[idx[1:0]] & wdata;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
      err    <= 1'b0;
    end else if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
      err    <= 1'b0;
    end else begin
      rvalid <= rd_req;
      err    <= prog_req && !prog_ok;
      if (rd_req)
        rdata <= rd_word;
    end
  end
endmodule

module otp_prot_reg_chk #(
  parameter int ADDR_W = 21,
  parameter int DW = 16
) (
  input logic               clk,
  input logic               por_n,
  input logic               rst_n,
  input logic               prog_req,
  input logic               rd_req,
  input logic [ADDR_W-1:0]  addr,
  input logic               rvalid,
  input logic               locked,
  input logic               err,
  input logic [4*DW-1:0]    user_flat
);
  // R11
  err_cause_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    err |-> $past(prog_req));
  // R11
  rvalid_cause_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    rvalid |-> $past(rd_req));
  // R10
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    $past(locked) |-> locked);
  // R7
  locked_frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
    locked |=> $stable(user_flat));
  // R3
  good_prog_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (prog_req && !locked && addr[ADDR_W-1:8] == '0 && addr[7:0] >= 8'h85 && addr[7:0] <= 8'h88)
      |=> !err);
endmodule

bind otp_prot_reg otp_prot_reg_chk #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .prog_req(prog_req), .rd_req(rd_req),
  .addr(addr), .rvalid(rvalid), .locked(locked), .err(err), .user_flat(user_q)
);

// File: tb/tb_otp_prot_reg.sv
module tb_otp_prot_reg;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam logic [4*DW-1:0] FAC = 64'h4D2C_0F15_A5A5_1234;

  logic clk = 0, por_n = 0, rst_n = 1;
  logic prog_req = 0, lock_req = 0, rd_req = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rvalid, locked, err;

  int checks = 0, errors = 0;
  logic [DW-1:0] exp_user [4];
  logic exp_lock;

  always #2 clk = ~clk;

  otp_prot_reg #(.ADDR_W(AW), .DW(DW), .FACTORY(FAC)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .prog_req(prog_req), .lock_req(lock_req),
    .rd_req(rd_req), .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .locked(locked), .err(err));

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model_rd(input logic [AW-1:0] a);
    logic [7:0] l;
    l = a[7:0];
    if (a[AW-1:8] != '0) return '0;
    if (l == 8'h80) return exp_lock ? 16'h0000 : 16'h0002;
    if (l >= 8'h81 && l <= 8'h84) return FAC[(l-8'h81)*DW +: DW];
    if (l >= 8'h85 && l <= 8'h88) return exp_user[l-8'h85];
    return '0;
  endfunction

  task automatic do_read(input logic [AW-1:0] a, input string tag);
    logic [DW-1:0] e;
    e = model_rd(a);
    @(negedge clk); rd_req = 1; addr = a;
    @(negedge clk); rd_req = 0;
    chk(rvalid === 1'b1 && rdata === e, tag, {15'b0, rvalid, rdata}, {16'h0001, e});
  endtask

  task automatic do_prog(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    logic good;
    logic [7:0] l;
    l = a[7:0];
    good = (a[AW-1:8] == '0) && l >= 8'h85 && l <= 8'h88 && !exp_lock;
    @(negedge clk); prog_req = 1; addr = a; wdata = d;
    @(negedge clk); prog_req = 0;
    if (good) exp_user[l-8'h85] = exp_user[l-8'h85] & d;
    chk(err === !good, tag, {31'b0, err}, {31'b0, !good});
  endtask

  task automatic do_lock(input logic [AW-1:0] a);
    @(negedge clk); lock_req = 1; addr = a;
    @(negedge clk); lock_req = 0;
    if (a == AW'(8'h80)) exp_lock = 1;
  endtask

  task automatic power_on;
    por_n = 0;
    repeat (2) @(negedge clk);
    por_n = 1;
    exp_lock = 0;
    for (int i = 0; i < 4; i++) exp_user[i] = '1;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    power_on();
    // R1 reset state
    chk(locked === 0 && err === 0 && rvalid === 0, "R1 reset outputs", {locked, err, rvalid}, 0);
    for (int j = 0; j < 4; j++) do_read(AW'(8'h85 + j), "R1 user erased");
    do_read(AW'(8'h80), "R8 status unlocked");
    // R2 R5 read sweep across all low bytes
    for (int l = 0; l < 256; l++) do_read(AW'(l), "R2 R5 read sweep");
    do_read(AW'(9'h181), "R5 high bit read");
    do_read(AW'(21'h100085), "R5 top bit read");
    @(negedge clk);
    chk(rvalid === 0, "R11 rvalid one cycle", {31'b0, rvalid}, 0);
    // R3 R4 R5 program sweep
    for (int l = 8'h7F; l <= 8'h89; l++) do_prog(AW'(l), 16'h00FF ^ 16'(l), "R3 R4 R5 prog sweep");
    do_prog(AW'(9'h186), 16'h0000, "R5 high bit prog");
    for (int j = 0; j < 4; j++) do_prog(AW'(8'h85 + j), 16'hF0F0 >> j, "R3 AND program");
    @(negedge clk);
    chk(err === 0, "R11 err one cycle", {31'b0, err}, 0);
    for (int l = 8'h80; l <= 8'h89; l++) do_read(AW'(l), "R3 R4 readback");
    // R6 wrong-address locks
    do_lock(AW'(8'h81));
    chk(locked === 0, "R6 lock at 0x81", {31'b0, locked}, 0);
    do_lock(AW'(9'h180));
    chk(locked === 0, "R6 lock high bit", {31'b0, locked}, 0);
    do_lock(AW'(8'h80));
    chk(locked === 1, "R6 lock set", {31'b0, locked}, 1);
    do_read(AW'(8'h80), "R8 status locked");
    // R7
    for (int j = 0; j < 4; j++) do_prog(AW'(8'h85 + j), 16'h0000, "R7 locked prog");
    for (int j = 0; j < 4; j++) do_read(AW'(8'h85 + j), "R7 locked readback");
    // R9 command reset
    @(negedge clk); prog_req = 1; addr = AW'(8'h81); rd_req = 1;
    @(negedge clk); prog_req = 0; rd_req = 0; rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk(err === 0 && rvalid === 0 && rdata === 0, "R9 cmd reset clears outputs", {err, rvalid, rdata}, 0);
    chk(locked === 1, "R9 R10 lock survives cmd reset", {31'b0, locked}, 1);
    for (int j = 0; j < 4; j++) do_read(AW'(8'h85 + j), "R9 user survives cmd reset");
    // R10 power-on
    power_on();
    chk(locked === 0, "R10 por clears lock", {31'b0, locked}, 0);
    for (int j = 0; j < 4; j++) do_read(AW'(8'h85 + j), "R10 user restored");
    do_prog(AW'(8'h88), 16'h1234, "R3 R10 prog after por");
    do_read(AW'(8'h88), "R3 R10 readback after por");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule